// File: doc/BRIEF.md
# Table-Scanned Multi-Channel Tick Timer

This block holds a bank of software-style countdown timers in a small table and serves all of them with a single shared decrementer. Each tick starts a walk through the table. The walk visits one entry per clock cycle in ascending index order and counts down every entry that is enabled. When an entry runs out, the block pulses that timer's expiry bit. The entry then either reloads its period or disables itself, depending on its mode.

A host sets up a timer by placing a 32-bit command word on `cmd_word` and pulsing `set_stb`. The host cannot write the enable bitmap and the mode bitmap directly; they change only through this command or through one-shot expiry. A free-running counter records how many ticks the engine has accepted. Each table entry holds a count and a period of `CNT_W` bits, which is 4 bytes per timer with the defaults.

Top module: `tick_timer_bank`

## Requirements
- R1: While `rst_n` is low and after it is released, `valid_map`, `mode_map`, `expire` and `tick_count` are all zero.
- R2: The command word carries enable in bit 31, restart in bit 30, the timer index in bits 19:16 and the period in bits `CNT_W-1:0`. In the cycle of `set_stb`, the indexed timer's enable bit takes bit 31, its mode bit takes bit 30, and its count and stored period take the period field. A command with bit 31 clear disables the timer.
- R3: An accepted tick starts a scan. On each of the next `NUM_TIMERS` clock edges the scan handles one entry, from index 0 upward. An entry is decremented only if its enable bit is set.
- R4: When an enabled entry with count 1 is handled, bit i of `expire` (i being the timer index) is 1 for exactly one cycle, starting the cycle after that entry is handled. At most one bit of `expire` is set at a time.
- R5: On expiry, a restart-mode entry (mode 1) reloads its period and stays enabled, while a one-shot entry (mode 0) clears its enable bit. No enable bit rises and no mode bit changes except through `set_stb`.
- R6: `tick_count` increments by one for every accepted tick, whether or not any timer is enabled.
- R7: A tick that arrives while a scan is running is held pending and starts a new scan right after the current one ends. Only one tick is held.
- R8: A set-timer command to the entry the scan is handling in that same cycle takes priority. The entry takes the command's values, and that visit neither decrements it nor expires it.
- R9: A period of 0 gives an interval of 2^`CNT_W` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 32 | Set-timer command word |
| set_stb | input | 1 | One-cycle strobe that executes `cmd_word` |
| tick | input | 1 | Timer tick request |
| valid_map | output | NUM_TIMERS | Enable bitmap, one bit per timer |
| mode_map | output | NUM_TIMERS | Mode bitmap, 1 = restart, 0 = one-shot |
| expire | output | NUM_TIMERS | One-cycle expiry pulse per timer |
| tick_count | output | TICK_W | Count of accepted ticks |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a host command and the scan's update of the same entry. The bench starts a scan and raises `set_stb` for timer 2 exactly on the edge where the scan handles entry 2. At that moment, timer 2 is a one-shot entry with count 1, so an update by the scan would expire it and disable it. The test passes when no expiry for timer 2 appears and timer 2 ends up enabled in restart mode.

The second pair is a new tick and a running scan. The bench sends a second tick in the middle of a scan and expects the tick counter to advance twice and a restart timer to expire on the second walk.

// File: rtl/tt_pkg.sv
package tt_pkg;
  // Field positions in the set-timer command word (LSB-0 numbering).
  localparam int CMD_EN_BIT  = 31;
  localparam int CMD_RS_BIT  = 30;
  localparam int CMD_IDX_LSB = 16;
  localparam int CMD_PER_LSB = 0;
endpackage

// File: rtl/tt_cmd_decode.sv
module tt_cmd_decode #(
  parameter int NUM_TIMERS = 16,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(NUM_TIMERS)
) (
  input  logic [31:0]      cmd_word,
  output logic             cmd_en,
  output logic             cmd_restart,
  output logic [IDX_W-1:0] cmd_idx,
  output logic [CNT_W-1:0] cmd_period
);
  import tt_pkg::*;

  logic unused_cmd;

  always_comb begin
    cmd_en      = cmd_word[CMD_EN_BIT];
    cmd_restart = cmd_word[CMD_RS_BIT];
    cmd_idx     = cmd_word[CMD_IDX_LSB +: IDX_W];
    cmd_period  = cmd_word[CMD_PER_LSB +: CNT_W];
  end

  assign unused_cmd = ^cmd_word;
endmodule

// File: rtl/tt_scan_seq.sv
module tt_scan_seq #(
  parameter int NUM_TIMERS = 16,
  localparam int IDX_W     = $clog2(NUM_TIMERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic             scan_act,
  output logic [IDX_W-1:0] scan_ptr,
  output logic             tick_accept
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TIMERS - 1);

  logic             act_q, act_n;
  logic             pend_q, pend_n;
  logic [IDX_W-1:0] ptr_q, ptr_n;
  logic             at_last;

  always_comb begin
    at_last     = act_q && (ptr_q == LAST);
    tick_accept = (!act_q && tick) || (at_last && (pend_q || tick));
    pend_n      = (act_q && !at_last) ? (pend_q || tick) : 1'b0;
    act_n       = act_q;
    ptr_n       = ptr_q;
    if (tick_accept) begin
      act_n = 1'b1;
      ptr_n = '0;
    end else if (at_last) begin
      act_n = 1'b0;
    end else if (act_q) begin
      ptr_n = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      act_q  <= act_n;
      pend_q <= pend_n;
      if (act_q || tick_accept) ptr_q <= ptr_n;
    end
  end

  assign scan_act = act_q;
  assign scan_ptr = ptr_q;

  // R3: the scan walks the entries upward, one entry per cycle.
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ptr_q != LAST) |=> (act_q && ptr_q == $past(ptr_q) + 1'b1));

  // R7: a pending tick always restarts the scan at entry 0.
  p_pend_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && pend_q) |=> (act_q && ptr_q == '0));
endmodule

// File: rtl/tt_timer_table.sv
module tt_timer_table #(
  parameter int NUM_TIMERS = 16,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(NUM_TIMERS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_act,
  input  logic [IDX_W-1:0]      scan_ptr,
  input  logic                  set_stb,
  input  logic                  cmd_en,
  input  logic                  cmd_restart,
  input  logic [IDX_W-1:0]      cmd_idx,
  input  logic [CNT_W-1:0]      cmd_period,
  output logic [NUM_TIMERS-1:0] valid_map,
  output logic [NUM_TIMERS-1:0] mode_map,
  output logic [NUM_TIMERS-1:0] expire
);
  logic [CNT_W-1:0]      cnt_q [NUM_TIMERS];
  logic [CNT_W-1:0]      cnt_n [NUM_TIMERS];
  logic [CNT_W-1:0]      per_q [NUM_TIMERS];
  logic [CNT_W-1:0]      per_n [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] val_q, val_n, mod_q, mod_n, exp_q, exp_n;
  logic                  scan_hit, upd_en;

  always_comb begin
    cnt_n    = cnt_q;
    per_n    = per_q;
    val_n    = val_q;
    mod_n    = mod_q;
    exp_n    = '0;
    scan_hit = scan_act && val_q[scan_ptr] && !(set_stb && cmd_idx == scan_ptr);
    if (scan_hit) begin
      if (cnt_q[scan_ptr] == CNT_W'(1)) begin
        exp_n[scan_ptr] = 1'b1;
        if (mod_q[scan_ptr]) begin
          cnt_n[scan_ptr] = per_q[scan_ptr];
        end else begin
          cnt_n[scan_ptr] = '0;
          val_n[scan_ptr] = 1'b0;
        end
      end else begin
        cnt_n[scan_ptr] = cnt_q[scan_ptr] - 1'b1;
      end
    end
    if (set_stb) begin
      cnt_n[cmd_idx] = cmd_period;
      per_n[cmd_idx] = cmd_period;
      val_n[cmd_idx] = cmd_en;
      mod_n[cmd_idx] = cmd_restart;
    end
    upd_en = scan_act || set_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TIMERS; i++) begin
        cnt_q[i] <= '0;
        per_q[i] <= '0;
      end
      val_q <= '0;
      mod_q <= '0;
      exp_q <= '0;
    end else begin
      exp_q <= exp_n;
      if (upd_en) begin
        cnt_q <= cnt_n;
        per_q <= per_n;
        val_q <= val_n;
        mod_q <= mod_n;
      end
    end
  end

  assign valid_map = val_q;
  assign mode_map  = mod_q;
  assign expire    = exp_q;

  // R4: at most one expiry bit is raised in any cycle.
  p_expire_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(expire));

  // R5: without a command, no enable bit can rise.
  p_no_silent_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !set_stb |=> ((val_q & ~$past(val_q)) == '0));

  // R5: without a command, the mode bitmap holds its value.
  p_mode_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !set_stb |=> $stable(mod_q));

  // R2: after a strobe, the addressed entry's enable bit matches the command.
  p_cmd_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> (val_q[$past(cmd_idx)] == $past(cmd_en)));
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int NUM_TIMERS = 16,
  parameter int CNT_W      = 16,
  parameter int TICK_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           cmd_word,
  input  logic                  set_stb,
  input  logic                  tick,
  output logic [NUM_TIMERS-1:0] valid_map,
  output logic [NUM_TIMERS-1:0] mode_map,
  output logic [NUM_TIMERS-1:0] expire,
  output logic [TICK_W-1:0]     tick_count
);
  localparam int IDX_W = $clog2(NUM_TIMERS);

  logic             cmd_en, cmd_restart;
  logic [IDX_W-1:0] cmd_idx, scan_ptr;
  logic [CNT_W-1:0] cmd_period;
  logic             scan_act, tick_accept;
  logic [TICK_W-1:0] tcnt_q, tcnt_n;

  tt_cmd_decode #(.NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W)) u_dec (
    .cmd_word   (cmd_word),
    .cmd_en     (cmd_en),
    .cmd_restart(cmd_restart),
    .cmd_idx    (cmd_idx),
    .cmd_period (cmd_period)
  );

  tt_scan_seq #(.NUM_TIMERS(NUM_TIMERS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .scan_act   (scan_act),
    .scan_ptr   (scan_ptr),
    .tick_accept(tick_accept)
  );

  tt_timer_table #(.NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_act   (scan_act),
    .scan_ptr   (scan_ptr),
    .set_stb    (set_stb),
    .cmd_en     (cmd_en),
    .cmd_restart(cmd_restart),
    .cmd_idx    (cmd_idx),
    .cmd_period (cmd_period),
    .valid_map  (valid_map),
    .mode_map   (mode_map),
    .expire     (expire)
  );

  always_comb tcnt_n = tcnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tcnt_q <= '0;
    else if (tick_accept) tcnt_q <= tcnt_n;
  end

  assign tick_count = tcnt_q;

  // R6: the tick counter never moves by more than one per cycle.
  p_tick_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tcnt_q == $past(tcnt_q) || tcnt_q == $past(tcnt_q) + 1'b1));
endmodule

// File: tb/tick_timer_bank_bench.sv
`timescale 1ns/1ps
module tick_timer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        set_stb = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] valid_map, mode_map, expire;
  logic [31:0] tick_count;

  logic [31:0] n_cmd = '0;
  logic        n_set = 1'b0;
  logic        n_tick = 1'b0;
  logic [15:0] n_valid, n_mode, n_exp;
  logic [31:0] n_tcnt;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] acc;

  always #2 clk = ~clk;

  tick_timer_bank u_tick_timer_bank (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .set_stb(set_stb), .tick(tick),
    .valid_map(valid_map), .mode_map(mode_map), .expire(expire), .tick_count(tick_count)
  );

  tick_timer_bank #(.CNT_W(4)) u_tick_timer_bank_narrow (
    .clk(clk), .rst_n(rst_n), .cmd_word(n_cmd), .set_stb(n_set), .tick(n_tick),
    .valid_map(n_valid), .mode_map(n_mode), .expire(n_exp), .tick_count(n_tcnt)
  );

  typedef struct packed {
    logic [31:0] cmd;
    logic [7:0]  nticks;
    logic [15:0] exp_val;
    logic [15:0] exp_mode;
    logic [15:0] exp_fire;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'hC000_0002, 8'd1, 16'h0001, 16'h0001, 16'h0000},
    '{32'h8003_0001, 8'd1, 16'h0001, 16'h0001, 16'h0009},
    '{32'hC00F_0003, 8'd2, 16'h8001, 16'h8001, 16'h0001},
    '{32'h0000_0005, 8'd1, 16'h8000, 16'h8000, 16'h8000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send_cmd(input logic [31:0] w);
    @(negedge clk); cmd_word = w; set_stb = 1'b1;
    @(negedge clk); set_stb = 1'b0;
  endtask

  task automatic run_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; acc |= expire;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); acc |= expire;
    end
  endtask

  task automatic run_narrow_tick();
    @(negedge clk); n_tick = 1'b1;
    @(negedge clk); n_tick = 1'b0; acc |= n_exp;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); acc |= n_exp;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid_map", 32'(valid_map), 32'h0);
    check("R1 mode_map", 32'(mode_map), 32'h0);
    check("R1 expire", 32'(expire), 32'h0);
    check("R1 tick_count", tick_count, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 tick_count after release", tick_count, 32'h0);

    // R2 R3 R4 R5: vector walk
    for (int v = 0; v < 4; v++) begin
      send_cmd(VECS[v].cmd);
      acc = '0;
      for (int t = 0; t < int'(VECS[v].nticks); t++) run_tick();
      check("R2 R5 valid_map", 32'(valid_map), 32'(VECS[v].exp_val));
      check("R2 R5 mode_map", 32'(mode_map), 32'(VECS[v].exp_mode));
      check("R3 R4 expire seen", 32'(acc), 32'(VECS[v].exp_fire));
    end
    check("R6 tick_count", tick_count, 32'd5);

    // R8: command lands on the edge where the scan handles entry 2
    send_cmd(32'h8002_0001);
    acc = '0;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; acc |= expire;
    @(negedge clk); acc |= expire;
    @(negedge clk); acc |= expire; cmd_word = 32'hC002_0005; set_stb = 1'b1;
    @(negedge clk); acc |= expire; set_stb = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); acc |= expire;
    end
    check("R8 no expiry on collision", 32'(acc), 32'h0);
    check("R8 valid_map", 32'(valid_map), 32'h8004);
    check("R8 mode_map", 32'(mode_map), 32'h8004);

    // R7: second tick during a scan is held and served
    acc = '0;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (4) @(negedge clk);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    for (int k = 0; k < 45; k++) begin
      @(negedge clk); acc |= expire;
    end
    check("R7 tick_count", tick_count, 32'd8);
    check("R7 expire on second scan", 32'(acc), 32'h8000);

    // R6: tick counted with no timer enabled (narrow instance)
    acc = '0;
    run_narrow_tick();
    check("R6 count with no timers", n_tcnt, 32'd1);

    // R9: period 0 means 2^CNT_W ticks (CNT_W = 4 -> 16)
    @(negedge clk); n_cmd = 32'h8001_0000; n_set = 1'b1;
    @(negedge clk); n_set = 1'b0;
    acc = '0;
    for (int t = 0; t < 15; t++) run_narrow_tick();
    check("R9 no expiry before 16 ticks", 32'(acc), 32'h0);
    check("R9 still enabled", 32'(n_valid), 32'h0002);
    run_narrow_tick();
    check("R9 expiry at tick 16", 32'(acc), 32'h0002);
    check("R9 one-shot disabled", 32'(n_valid), 32'h0000);

    finish_run();
  end
endmodule